// File: doc/BRIEF.md
# Debug Trace Capture Controller

This block decides, cycle by cycle, which bus events from two bus masters are written into an on-chip trace buffer during a debug session. The two masters are a main CPU and a coprocessor. Each master presents a valid strobe, a change-of-flow flag, an address and a data word. A single 8-bit control register holds four settings: which master is traced, the storage mode, an address-range filter and where the trigger falls within the capture window. Software loads the register while the session is disarmed. Writes to the source field are also refused while the secure input is high.

A four-state machine runs the session. IDLE is the state while disarmed. Raising `armed` moves it IDLE→PRE. In PRE it waits for the trigger. A trigger moves it PRE→POST for begin or middle alignment, or PRE→DONE for end alignment. POST counts the entries stored after the trigger. When the limit is reached it moves POST→DONE, and no further entries are stored. Dropping `armed` returns it from PRE, POST or DONE to IDLE. Each accepted event is presented on the buffer write port one clock after it is sampled. The trace RAM and the comparators that produce the range bounds are outside this block.

Top module: `trace_capture_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `tb_we` is 0 and `done` is 0.
- R2: A write updates bits [5:0] (mode [5:4], range [3:2], align [1:0]) only while `armed` is low. It updates bits [7:6] only while both `armed` and `secure` are low. A write made while armed leaves the read-back value unchanged.
- R3: While `secure` is high, the source field reads 00, no entry is stored, and writes to the source field are ignored.
- R4: Source codes are 00 none, 01 CPU only, 10 coprocessor only and 11 both. Mode 00 (normal) and mode 11 store only events that have both valid and change-of-flow set.
- R5: In mode 01 (loop), a change-of-flow event whose address equals the last address stored from the same master since arming is dropped. Any other change-of-flow event is stored.
- R6: In mode 10 (detail), every valid CPU access is stored whether or not its change-of-flow flag is set. Coprocessor events are never stored in detail mode.
- R7: In detail mode with source 01, range code 00 keeps all accesses, 01 keeps addr >= `rng_lo`, 10 keeps addr <= `rng_hi`, and 11 keeps `rng_lo` <= addr <= `rng_hi`. With source 11 the range code is ignored.
- R8: Begin alignment (align 00 or 11) stores nothing before or in the trigger cycle. It stores exactly 64 entries after the trigger, and `done` rises in the cycle the 64th entry appears.
- R9: End alignment (align 10) stores from arming up to and including the trigger cycle. `done` then rises and nothing more is stored.
- R10: Middle alignment (align 01) stores before the trigger and in the trigger cycle. It then stores exactly 32 more entries, with `done` rising alongside the 32nd.
- R11: If both masters qualify in the same cycle, only the CPU entry is written. `tb_src` is 0 for a CPU entry and 1 for a coprocessor entry.
- R12: An entry appears on `tb_we`/`tb_src`/`tb_addr`/`tb_data` one clock after its event is sampled. Dropping `armed` clears `done` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register read-back |
| armed | input | 1 | Session armed (level) |
| secure | input | 1 | System secured |
| trig | input | 1 | Trigger pulse |
| rng_lo | input | AW | Lower address bound for range filtering |
| rng_hi | input | AW | Upper address bound for range filtering |
| cpu_vld | input | 1 | CPU access valid |
| cpu_cof | input | 1 | CPU change-of-flow flag |
| cpu_addr | input | AW | CPU address |
| cpu_data | input | DW | CPU data |
| cop_vld | input | 1 | Coprocessor access valid |
| cop_cof | input | 1 | Coprocessor change-of-flow flag |
| cop_addr | input | AW | Coprocessor address |
| cop_data | input | DW | Coprocessor data |
| tb_we | output | 1 | Trace buffer write enable |
| tb_src | output | 1 | Entry source (0 CPU, 1 coprocessor) |
| tb_addr | output | AW | Entry address |
| tb_data | output | DW | Entry data |
| done | output | 1 | Capture session complete |

## Verification
Every stored entry is due on the buffer port exactly one clock after the cycle in which its event was driven. `done` reflects the state register, so it is due in the same cycle as the entry that completes the window. The driver changes inputs on the falling edge and queues the entry it expects. The monitor samples just after each rising edge and matches every write against the queue in order. After each scenario two idle cycles pass, and then the queue must be empty. This catches entries that went missing as well as extra ones. `done` and the register read-back are checked immediately after the edge that should change them.

// File: rtl/trc_pkg.sv
package trc_pkg;
    typedef enum logic [1:0] {SRC_NONE = 2'b00, SRC_CPU = 2'b01, SRC_COP = 2'b10, SRC_BOTH = 2'b11} trc_src_e;
    typedef enum logic [1:0] {MD_NORMAL = 2'b00, MD_LOOP = 2'b01, MD_DETAIL = 2'b10, MD_SPARE = 2'b11} trc_mode_e;
    typedef enum logic [1:0] {AL_BEGIN = 2'b00, AL_MID = 2'b01, AL_END = 2'b10, AL_BEGIN_ALT = 2'b11} trc_align_e;
    typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_POST, ST_DONE} trc_state_e;

    typedef struct packed {
        trc_src_e   src;
        trc_mode_e  mode;
        logic [1:0] rng;
        trc_align_e align;
    } trc_cfg_t;
endpackage

// File: rtl/trc_cfg_reg.sv
module trc_cfg_reg
    import trc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       armed,
    input  logic       secure,
    output trc_cfg_t   cfg
);
    logic low_ok;
    logic src_ok;

    assign low_ok = wr_en && !armed;
    assign src_ok = low_ok && !secure;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            if (low_ok) begin
                cfg.mode  <= trc_mode_e'(wr_data[5:4]);
                cfg.rng   <= wr_data[3:2];
                cfg.align <= trc_align_e'(wr_data[1:0]);
            end
            if (secure)
                cfg.src <= SRC_NONE;
            else if (src_ok)
                cfg.src <= trc_src_e'(wr_data[7:6]);
        end
    end

    p_low_hold_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> $stable(cfg[5:0]));
    p_src_cleared_secure_r3: assert property (@(posedge clk) disable iff (!rst_n)
        secure |=> (cfg.src == SRC_NONE));
endmodule

// File: rtl/trc_src_filter.sv
module trc_src_filter
    import trc_pkg::*;
#(
    parameter int AW     = 16,
    parameter bit IS_COP = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  trc_mode_e     mode,
    input  logic [1:0]    rng,
    input  logic          range_on,
    input  logic          selected,
    input  logic          vld,
    input  logic          cof,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic          stored,
    output logic          hit
);
    logic [AW-1:0] last_q;
    logic          last_v;
    logic          in_rng;
    logic          detail_ok;

    always_comb begin
        unique case (rng)
            2'b00:   in_rng = 1'b1;
            2'b01:   in_rng = (addr >= lo);
            2'b10:   in_rng = (addr <= hi);
            default: in_rng = (addr >= lo) && (addr <= hi);
        endcase
    end

    generate
        if (IS_COP) begin : g_cop
            assign detail_ok = 1'b0;
        end else begin : g_cpu
            assign detail_ok = !range_on || in_rng;
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        if (selected && vld) begin
            unique case (mode)
                MD_NORMAL, MD_SPARE: hit = cof;
                MD_LOOP:             hit = cof && !(last_v && (last_q == addr));
                MD_DETAIL:           hit = detail_ok;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
            last_v <= 1'b0;
        end else if (clr) begin
            last_v <= 1'b0;
        end else if (stored) begin
            last_q <= addr;
            last_v <= 1'b1;
        end
    end

    p_loop_no_repeat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stored && mode == MD_LOOP && last_v) |-> (addr != last_q));

    generate
        if (IS_COP) begin : g_cop_chk
            p_cop_no_detail_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == MD_DETAIL) |-> !stored);
        end
    endgenerate
endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
    import trc_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    input  logic          armed,
    input  logic          secure,
    input  logic          trig,
    input  logic [AW-1:0] rng_lo,
    input  logic [AW-1:0] rng_hi,
    input  logic          cpu_vld,
    input  logic          cpu_cof,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_data,
    input  logic          cop_vld,
    input  logic          cop_cof,
    input  logic [AW-1:0] cop_addr,
    input  logic [DW-1:0] cop_data,
    output logic          tb_we,
    output logic          tb_src,
    output logic [AW-1:0] tb_addr,
    output logic [DW-1:0] tb_data,
    output logic          done
);
    localparam int HALF = DEPTH / 2;
    localparam int CW   = $clog2(DEPTH);
    localparam int NSRC = 2;

    trc_cfg_t   cfg;
    trc_src_e   eff_src;
    trc_state_e state, state_nx;
    logic [CW-1:0] cnt, cnt_last;
    logic [NSRC-1:0] src_on, hit, store, vld_a, cof_a;
    logic [AW-1:0] addr_a [NSRC];
    logic align_begin, cap;

    trc_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
        .armed(armed), .secure(secure), .cfg(cfg)
    );
    assign cfg_rdata = cfg;

    assign eff_src   = secure ? SRC_NONE : cfg.src;
    assign src_on[0] = (eff_src == SRC_CPU) || (eff_src == SRC_BOTH);
    assign src_on[1] = (eff_src == SRC_COP) || (eff_src == SRC_BOTH);
    assign vld_a     = {cop_vld, cpu_vld};
    assign cof_a     = {cop_cof, cpu_cof};
    assign addr_a[0] = cpu_addr;
    assign addr_a[1] = cop_addr;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            trc_src_filter #(.AW(AW), .IS_COP(g == 1)) u_flt (
                .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE),
                .mode(cfg.mode), .rng(cfg.rng),
                .range_on((g == 0) && (eff_src == SRC_CPU)),
                .selected(src_on[g]), .vld(vld_a[g]), .cof(cof_a[g]),
                .addr(addr_a[g]), .lo(rng_lo), .hi(rng_hi),
                .stored(store[g]), .hit(hit[g])
            );
        end
    endgenerate

    assign align_begin = (cfg.align == AL_BEGIN) || (cfg.align == AL_BEGIN_ALT);
    assign cap         = armed && ((state == ST_PRE && !align_begin) || state == ST_POST);
    assign store[0]    = hit[0] && cap;
    assign store[1]    = hit[1] && cap && !hit[0];
    assign cnt_last    = (cfg.align == AL_MID) ? CW'(HALF - 1) : CW'(DEPTH - 1);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (armed) state_nx = ST_PRE;
            ST_PRE: begin
                if (!armed)    state_nx = ST_IDLE;
                else if (trig) state_nx = (cfg.align == AL_END) ? ST_DONE : ST_POST;
            end
            ST_POST: begin
                if (!armed)                           state_nx = ST_IDLE;
                else if ((|store) && cnt == cnt_last) state_nx = ST_DONE;
            end
            ST_DONE: if (!armed) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state != ST_POST) cnt <= '0;
            else if (|store)      cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_we   <= 1'b0;
            tb_src  <= 1'b0;
            tb_addr <= '0;
            tb_data <= '0;
        end else begin
            tb_we   <= |store;
            tb_src  <= !store[0];
            tb_addr <= store[0] ? cpu_addr : cop_addr;
            tb_data <= store[0] ? cpu_data : cop_data;
        end
    end

    assign done = (state == ST_DONE);

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> !tb_we);
    p_post_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POST) |-> (cnt <= cnt_last));
    p_cpu_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && hit[0]) |=> (tb_we && !tb_src));
    p_disarm_clears_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !done);
endmodule

// File: tb/trace_capture_ctrl_bench.sv
`timescale 1ns/1ps
module trace_capture_ctrl_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0; logic [7:0] cfg_wdata = '0; logic [7:0] cfg_rdata;
    logic armed = 1'b0, secure = 1'b0, trig = 1'b0;
    logic [15:0] rng_lo = '0, rng_hi = '0;
    logic cpu_vld = 1'b0, cpu_cof = 1'b0, cop_vld = 1'b0, cop_cof = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_data = '0, cop_addr = '0, cop_data = '0;
    logic tb_we, tb_src, done;
    logic [15:0] tb_addr, tb_data;

    int n_chk = 0, n_bad = 0;
    logic [32:0] exp_q[$];
    string tag_q[$];
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    trace_capture_ctrl u_trace_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .armed(armed), .secure(secure), .trig(trig), .rng_lo(rng_lo), .rng_hi(rng_hi),
        .cpu_vld(cpu_vld), .cpu_cof(cpu_cof), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cop_vld(cop_vld), .cop_cof(cop_cof), .cop_addr(cop_addr), .cop_data(cop_data),
        .tb_we(tb_we), .tb_src(tb_src), .tb_addr(tb_addr), .tb_data(tb_data), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compares every buffer write against the scoreboard
    initial forever begin
        @(posedge clk); #1;
        if (rst_n && tb_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, {cur_tag, " unexpected entry"}, {15'd0, tb_src, tb_addr}, 0);
            end else begin
                logic [32:0] e; string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                chk({tb_src, tb_addr, tb_data} == e, t, {tb_src, tb_addr, tb_data}, e);
            end
        end
    end

    task automatic step(input bit cv, input bit cc, input logic [15:0] ca,
                        input bit ov, input bit oc, input logic [15:0] oa,
                        input bit tg, input bit ec, input bit eo, input string tag);
        @(negedge clk);
        cur_tag = tag;
        cpu_vld = cv; cpu_cof = cc; cpu_addr = ca; cpu_data = ca ^ 16'h5A5A;
        cop_vld = ov; cop_cof = oc; cop_addr = oa; cop_data = oa ^ 16'hA5A5;
        trig = tg;
        if (ec)      begin exp_q.push_back({1'b0, ca, ca ^ 16'h5A5A}); tag_q.push_back(tag); end
        else if (eo) begin exp_q.push_back({1'b1, oa, oa ^ 16'hA5A5}); tag_q.push_back(tag); end
        @(posedge clk); #1;
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cpu_vld = 0; cpu_cof = 0; cop_vld = 0; cop_cof = 0; trig = 0;
        end
    endtask

    task automatic flush(input string tag);
        quiet(2); @(posedge clk); #1;
        chk(exp_q.size() == 0, {tag, " missing entries"}, exp_q.size(), 0);
        exp_q.delete(); tag_q.delete();
    endtask

    task automatic wcfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1; cfg_wdata = v;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic set_arm(input bit a);
        @(negedge clk); armed = a;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cfg_rdata == 8'h00, "R1 cfg", cfg_rdata, 0);
        chk(tb_we == 0 && done == 0, "R1 outputs", {tb_we, done}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(cfg_rdata == 8'h00 && !tb_we && !done, "R1 after release", cfg_rdata, 0);

        // end alignment, both sources, normal mode
        wcfg(8'hC2);
        chk(cfg_rdata == 8'hC2, "R2 write disarmed", cfg_rdata, 8'hC2);
        set_arm(1);
        step(1,1,16'h0100, 0,0,0, 0, 1,0, "R4 cpu cof");
        step(1,0,16'h0104, 0,0,0, 0, 0,0, "R4 no cof");
        step(0,0,0, 1,1,16'h0200, 0, 0,1, "R4 cop cof");
        step(1,1,16'h0110, 1,1,16'h0210, 0, 1,0, "R11 priority");
        step(1,1,16'h0300, 0,0,0, 1, 1,0, "R9 trigger cycle");
        chk(done == 1, "R9 done", done, 1);
        step(1,1,16'h0304, 0,0,0, 0, 0,0, "R9 after trigger");
        flush("R9");
        set_arm(0);
        @(negedge clk);
        chk(done == 0, "R12 disarm clears done", done, 0);

        // loop mode, CPU only, begin alignment
        wcfg(8'h50);
        set_arm(1);
        step(1,1,16'h0080, 0,0,0, 0, 0,0, "R8 before trigger");
        step(0,0,0, 0,0,0, 1, 0,0, "R8 trigger");
        step(1,1,16'h0010, 0,0,0, 0, 1,0, "R5 first");
        step(1,1,16'h0010, 0,0,0, 0, 0,0, "R5 repeat");
        step(1,1,16'h0020, 0,0,0, 0, 1,0, "R5 new");
        step(1,1,16'h0010, 0,0,0, 0, 1,0, "R5 back");
        step(0,0,0, 1,1,16'h0010, 0, 0,0, "R4 cop not selected");
        flush("R5");
        set_arm(0);

        // detail mode, CPU only, window range
        rng_lo = 16'h1000; rng_hi = 16'h1FFF;
        wcfg(8'h6C);
        set_arm(1);
        step(0,0,0, 0,0,0, 1, 0,0, "R7 trigger");
        step(1,0,16'h1500, 0,0,0, 0, 1,0, "R6 detail no cof");
        step(1,0,16'h0FFF, 0,0,0, 0, 0,0, "R7 below");
        step(1,1,16'h2000, 0,0,0, 0, 0,0, "R7 above");
        step(1,0,16'h1000, 0,0,0, 0, 1,0, "R7 low edge");
        step(1,0,16'h1FFF, 0,0,0, 0, 1,0, "R7 high edge");
        flush("R7");
        set_arm(0);

        // detail mode, both sources: range ignored, coprocessor silent
        wcfg(8'hEC);
        set_arm(1);
        step(0,0,0, 0,0,0, 1, 0,0, "R7 trigger both");
        step(1,0,16'h2000, 0,0,0, 0, 1,0, "R7 range ignored");
        step(0,0,0, 1,1,16'h0040, 0, 0,0, "R6 cop detail");
        flush("R6");
        set_arm(0);

        // security
        wcfg(8'h40);
        set_arm(1);
        step(0,0,0, 0,0,0, 1, 0,0, "R3 trigger");
        step(1,1,16'h0500, 0,0,0, 0, 1,0, "R3 before secure");
        @(negedge clk); secure = 1;
        step(1,1,16'h0504, 0,0,0, 0, 0,0, "R3 secured");
        flush("R3");
        chk(cfg_rdata[7:6] == 2'b00, "R3 src reads 00", cfg_rdata, 0);
        set_arm(0);
        wcfg(8'h41);
        chk(cfg_rdata == 8'h01, "R3 src write ignored", cfg_rdata, 8'h01);
        @(negedge clk); secure = 0;

        // write protection while armed
        wcfg(8'h41);
        set_arm(1);
        wcfg(8'h9E);
        chk(cfg_rdata == 8'h41, "R2 armed write blocked", cfg_rdata, 8'h41);

        // middle alignment (cfg 0x41 kept)
        for (int i = 0; i < 3; i++)
            step(1,1,16'h0600 + 16'(i*4), 0,0,0, 0, 1,0, "R10 pre");
        step(1,1,16'h0700, 0,0,0, 1, 1,0, "R10 trigger cycle");
        for (int i = 0; i < 32; i++) begin
            step(1,1,16'h0800 + 16'(i*4), 0,0,0, 0, 1,0, "R10 post");
            if (i == 30) chk(done == 0, "R10 not done at 31", done, 0);
        end
        chk(done == 1, "R10 done at 32", done, 1);
        step(1,1,16'h0900, 0,0,0, 0, 0,0, "R10 after done");
        flush("R10");
        set_arm(0);

        // begin alignment, full window
        wcfg(8'h40);
        set_arm(1);
        step(1,1,16'h0A00, 0,0,0, 1, 0,0, "R8 trigger cycle");
        for (int i = 0; i < 64; i++) begin
            step(1,1,16'h1000 + 16'(i*2), 0,0,0, 0, 1,0, "R8 post");
            if (i == 62) chk(done == 0, "R8 not done at 63", done, 0);
        end
        chk(done == 1, "R8 done at 64", done, 1);
        step(1,1,16'h3000, 0,0,0, 0, 0,0, "R8 after done");
        flush("R8");
        set_arm(0);
        @(negedge clk);
        chk(done == 0, "R12 done cleared", done, 0);

        finish_run();
    end
endmodule